// File: doc/BRIEF.md
# Signed Saturating Add Execute Unit

This unit decodes one instruction word per cycle and runs a signed 32-bit saturating addition. The instruction can be in one of two encodings. A mode input selects which one: a 32-bit fixed-width form that carries a 4-bit condition, or a compact form that always executes. The two operands arrive already read from the register file. The unit presents three things combinationally in the same cycle:

- the destination index and both source indices,
- the clamped sum,
- a write strobe, or an illegal-instruction indication when the word matches neither form.

A sticky saturation flag lives inside the unit. It is set on the clock edge that ends any executed addition that had to clamp. It stays set until a clear input drops it or reset is applied. The unit only reads the NZCV flags and never changes them.

Instructions are offered with `issue_valid`. The unit has no back-pressure: it accepts a word in every cycle where `issue_valid` is high and finishes it in that same cycle. For this reason it has no ready output, and the source of instructions never has to hold a word.

Top module: `satadd_exec_unit`

## Requirements
- R1: When the signed sum of `op_n` and `op_m` fits in 32 bits, `result` equals that sum exactly.
- R2: On positive overflow, `result` is 0x7FFFFFFF. On negative overflow, it is 0x80000000. Overflow means both operands have the same sign and the wrapped sum has the other sign.
- R3: An executed addition that clamps sets `sat_flag` at the next rising clock edge. An executed addition that does not clamp leaves a set flag at 1.
- R4: `sat_clr` clears `sat_flag` at the next edge. If an executed clamping addition happens in the same cycle, the flag ends up 1.
- R5: With `mode`=0, the word matches the fixed-width form when bits 27:20 = 8'h10, bits 11:4 = 8'h05 and bits 31:28 ≠ 4'hF. In that form the fields are: destination = bits 15:12, first source = bits 19:16, second source = bits 3:0.
- R6: With `mode`=1, the word matches the compact form when bits 31:20 = 12'hFA8, bits 15:12 = 4'hF and bits 7:4 = 4'h8. In that form the fields are: destination = bits 11:8, first source = bits 19:16, second source = bits 3:0.
- R7: The fixed-width form executes only if its condition (bits 31:28) passes. The flags input is `nzcv` = {N,Z,C,V}, with N in bit 3. The codes are:
  - 0 EQ Z
  - 1 NE !Z
  - 2 CS C
  - 3 CC !C
  - 4 MI N
  - 5 PL !N
  - 6 VS V
  - 7 VC !V
  - 8 HI C&!Z
  - 9 LS !C|Z
  - 10 GE N==V
  - 11 LT N!=V
  - 12 GT !Z&(N==V)
  - 13 LE Z|(N!=V)
  - 14 AL always

  A failed condition gives `wr_en`=0 and `illegal`=0, and leaves `sat_flag` unchanged.
- R8: A valid word that matches neither form (this includes condition code 4'hF) gives `illegal`=1 and `wr_en`=0, and leaves `sat_flag` unchanged.
- R9: The compact form executes whatever the value of `nzcv`.
- R10: Synchronous reset clears `sat_flag`.
- R11: With `issue_valid` low, `wr_en` and `illegal` are 0 and `sat_flag` is unchanged by the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction word is offered this cycle |
| mode | input | 1 | 0 = fixed-width form, 1 = compact form |
| instr | input | 32 | Instruction word |
| op_n | input | 32 | First source operand value |
| op_m | input | 32 | Second source operand value |
| nzcv | input | 4 | Current condition flags {N,Z,C,V} |
| sat_clr | input | 1 | Clear the sticky saturation flag |
| src_n_idx | output | 4 | Decoded first source register index |
| src_m_idx | output | 4 | Decoded second source register index |
| rd_idx | output | 4 | Decoded destination register index |
| wr_en | output | 1 | Write the result to the destination |
| result | output | 32 | Saturated sum |
| illegal | output | 1 | Valid word matches neither form |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The flag clear and the flag set can both occur in one cycle. The bench provokes this by raising `sat_clr` while it issues an executed addition that overflows. It then checks that the flag reads 1 after the edge. It repeats the same cycle with a non-clamping addition and expects 0. It also pairs `sat_clr` with a clamping addition that fails its condition, which must leave the flag cleared.

// File: rtl/satadd_pkg.sv
package satadd_pkg;

  localparam int unsigned IW = 32;
  localparam int unsigned RIDX_W = 4;

  // constant-field masks and patterns of the two forms
  localparam logic [IW-1:0] FIX_MASK = 32'h0FF0_0FF0;
  localparam logic [IW-1:0] FIX_PAT  = 32'h0100_0050;
  localparam logic [IW-1:0] CMP_MASK = 32'hFFF0_F0F0;
  localparam logic [IW-1:0] CMP_PAT  = 32'hFA80_F080;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic              hit;
    logic              uncond;
    cond_e             cond;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rm;
  } dec_t;

endpackage

// File: rtl/satadd_decode.sv
module satadd_decode
  import satadd_pkg::*;
(
  input  logic [IW-1:0] instr_i,
  input  logic          compact_i,
  output dec_t          dec_o
);

  logic fix_hit, cmp_hit;
  dec_t fix_d, cmp_d;

  assign fix_hit = ((instr_i & FIX_MASK) == FIX_PAT) && (instr_i[31:28] != 4'hF);
  assign cmp_hit = ((instr_i & CMP_MASK) == CMP_PAT);

  always_comb begin
    fix_d.hit    = fix_hit;
    fix_d.uncond = 1'b0;
    fix_d.cond   = cond_e'(instr_i[31:28]);
    fix_d.rn     = instr_i[19:16];
    fix_d.rd     = instr_i[15:12];
    fix_d.rm     = instr_i[3:0];

    cmp_d.hit    = cmp_hit;
    cmp_d.uncond = 1'b1;
    cmp_d.cond   = CC_AL;
    cmp_d.rn     = instr_i[19:16];
    cmp_d.rd     = instr_i[11:8];
    cmp_d.rm     = instr_i[3:0];
  end

  assign dec_o = compact_i ? cmp_d : fix_d;

  always_comb begin
    if (!compact_i && instr_i[31:28] == 4'hF)
      AST_NV_NOT_HIT: assert (!dec_o.hit); // R8
  end

endmodule

// File: rtl/satadd_cond.sv
module satadd_cond
  import satadd_pkg::*;
(
  input  cond_e  cond_i,
  input  flags_t flg_i,
  output logic   pass_o
);

  logic nv_eq;
  assign nv_eq = (flg_i.n == flg_i.v);

  always_comb begin
    unique case (cond_i)
      CC_EQ:   pass_o = flg_i.z;
      CC_NE:   pass_o = !flg_i.z;
      CC_CS:   pass_o = flg_i.c;
      CC_CC:   pass_o = !flg_i.c;
      CC_MI:   pass_o = flg_i.n;
      CC_PL:   pass_o = !flg_i.n;
      CC_VS:   pass_o = flg_i.v;
      CC_VC:   pass_o = !flg_i.v;
      CC_HI:   pass_o = flg_i.c && !flg_i.z;
      CC_LS:   pass_o = !flg_i.c || flg_i.z;
      CC_GE:   pass_o = nv_eq;
      CC_LT:   pass_o = !nv_eq;
      CC_GT:   pass_o = !flg_i.z && nv_eq;
      CC_LE:   pass_o = flg_i.z || !nv_eq;
      CC_AL:   pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/satadd_core.sv
module satadd_core #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);

  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] raw;
  logic         same_sign;

  assign raw       = a_i + b_i;
  assign same_sign = (a_i[W-1] == b_i[W-1]);
  assign sat_o     = same_sign && (raw[W-1] != a_i[W-1]);

  always_comb begin
    if (!sat_o)          res_o = raw;
    else if (a_i[W-1])   res_o = NEG_LIM;
    else                 res_o = POS_LIM;
  end

  always_comb begin
    if (a_i[W-1] != b_i[W-1])
      AST_MIXED_SIGN_NO_CLAMP: assert (res_o == raw); // R1
  end

endmodule

// File: rtl/satadd_exec_unit.sv
module satadd_exec_unit
  import satadd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        issue_valid,
  input  logic        mode,
  input  logic [31:0] instr,
  input  logic [31:0] op_n,
  input  logic [31:0] op_m,
  input  logic [3:0]  nzcv,
  input  logic        sat_clr,
  output logic [3:0]  src_n_idx,
  output logic [3:0]  src_m_idx,
  output logic [3:0]  rd_idx,
  output logic        wr_en,
  output logic [31:0] result,
  output logic        illegal,
  output logic        sat_flag
);

  dec_t dec;
  logic cond_ok;
  logic clamp;
  logic go;
  logic sat_q;

  satadd_decode u_dec (
    .instr_i   (instr),
    .compact_i (mode),
    .dec_o     (dec)
  );

  satadd_cond u_cond (
    .cond_i (dec.cond),
    .flg_i  (flags_t'(nzcv)),
    .pass_o (cond_ok)
  );

  satadd_core #(.W(IW)) u_core (
    .a_i   (op_n),
    .b_i   (op_m),
    .res_o (result),
    .sat_o (clamp)
  );

  assign go        = issue_valid && dec.hit && (dec.uncond || cond_ok);
  assign wr_en     = go;
  assign illegal   = issue_valid && !dec.hit;
  assign rd_idx    = dec.rd;
  assign src_n_idx = dec.rn;
  assign src_m_idx = dec.rm;
  assign sat_flag  = sat_q;

  // set beats clear when both land in one cycle
  always_ff @(posedge clk) begin
    if (rst)               sat_q <= 1'b0;
    else if (go && clamp)  sat_q <= 1'b1;
    else if (sat_clr)      sat_q <= 1'b0;
  end

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !wr_en); // R8
  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sat_flag && !sat_clr) |=> sat_flag); // R3
  AST_SAT_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (result == 32'h7FFF_FFFF || result == 32'h8000_0000)
     && (op_n[31] == op_m[31]) && (result[31] == op_n[31])
     && ((op_n + op_m) != result)) |=> sat_flag); // R3
  AST_CLR_WINS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (sat_clr && !issue_valid) |=> !sat_flag); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |-> (!wr_en && !illegal)); // R11
  AST_COMPACT_RD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode) |-> (rd_idx == instr[11:8])); // R6

endmodule

// File: tb/satadd_exec_unit_tb.sv
`timescale 1ns/1ps
module satadd_exec_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        issue_valid, mode, sat_clr;
  logic [31:0] instr, op_n, op_m, result;
  logic [3:0]  nzcv, src_n_idx, src_m_idx, rd_idx;
  logic        wr_en, illegal, sat_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  satadd_exec_unit u_dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .mode(mode),
    .instr(instr), .op_n(op_n), .op_m(op_m), .nzcv(nzcv), .sat_clr(sat_clr),
    .src_n_idx(src_n_idx), .src_m_idx(src_m_idx), .rd_idx(rd_idx),
    .wr_en(wr_en), .result(result), .illegal(illegal), .sat_flag(sat_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fx(input logic [3:0] c, input logic [3:0] n,
                                     input logic [3:0] d, input logic [3:0] m);
    return {c, 8'h10, n, d, 8'h05, m};
  endfunction

  function automatic logic [31:0] cp(input logic [3:0] n, input logic [3:0] d,
                                     input logic [3:0] m);
    return {12'hFA8, n, 4'hF, d, 4'h8, m};
  endfunction

  function automatic logic [31:0] sat_ref(input logic [31:0] a, input logic [31:0] b);
    longint s;
    s = longint'($signed(a)) + longint'($signed(b));
    if (s > 64'sd2147483647) return 32'h7FFF_FFFF;
    if (s < -64'sd2147483648) return 32'h8000_0000;
    return s[31:0];
  endfunction

  function automatic bit clamps(input logic [31:0] a, input logic [31:0] b);
    longint s;
    s = longint'($signed(a)) + longint'($signed(b));
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  function automatic bit cond_ref(input int c, input logic [3:0] f);
    bit n, z, cf, v;
    n = f[3]; z = f[2]; cf = f[1]; v = f[0];
    case (c)
      0: return z;         1: return !z;
      2: return cf;        3: return !cf;
      4: return n;         5: return !n;
      6: return v;         7: return !v;
      8: return cf && !z;  9: return !cf || z;
      10: return n == v;   11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  // drive at negedge, settle, leave for comb checks
  task automatic drive(input logic v, input logic md, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] f, input logic clr);
    @(negedge clk);
    issue_valid = v; mode = md; instr = ins; op_n = a; op_m = b;
    nzcv = f; sat_clr = clr;
    #1;
  endtask

  // one clocked step then return to idle and sample the flag
  task automatic clock_in(input logic [31:0] exp_flag, input string req);
    @(negedge clk);
    issue_valid = 1'b0; sat_clr = 1'b0;
    #1;
    chk(req, {31'd0, sat_flag}, exp_flag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; issue_valid = 1'b0; sat_clr = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  logic [31:0] corner [8];
  logic [31:0] lf;

  initial begin
    rst = 1'b1; issue_valid = 0; mode = 0; instr = 0; op_n = 0; op_m = 0;
    nzcv = 0; sat_clr = 0;
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h8000_0000; corner[5] = 32'h4000_0000;
    corner[6] = 32'hC000_0000; corner[7] = 32'h7FFF_FFFE;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R10 reset flag", {31'd0, sat_flag}, 32'd0);

    // R7: every condition code against every flag pattern
    for (int c = 0; c < 15; c++)
      for (int f = 0; f < 16; f++) begin
        drive(1, 0, fx(c[3:0], 4'd1, 4'd2, 4'd3), 32'd5, 32'd6, f[3:0], 0);
        chk("R7 cond gate", {31'd0, wr_en}, {31'd0, cond_ref(c, f[3:0])});
        chk("R7 cond not illegal", {31'd0, illegal}, 32'd0);
      end
    // R8: code 4'hF never matches
    for (int f = 0; f < 16; f++) begin
      drive(1, 0, fx(4'hF, 4'd1, 4'd2, 4'd3), 32'd5, 32'd6, f[3:0], 0);
      chk("R8 nv illegal", {31'd0, illegal}, 32'd1);
      chk("R8 nv no write", {31'd0, wr_en}, 32'd0);
    end
    // R9: compact form ignores flags
    for (int f = 0; f < 16; f++) begin
      drive(1, 1, cp(4'd4, 4'd5, 4'd6), 32'd1, 32'd1, f[3:0], 0);
      chk("R9 compact executes", {31'd0, wr_en}, 32'd1);
    end

    // R5/R6: field extraction over all indices
    for (int r = 0; r < 16; r++) begin
      drive(1, 0, fx(4'hE, r[3:0], 4'(r + 5), 4'(r + 9)), 32'd0, 32'd0, 4'd0, 0);
      chk("R5 rd", {28'd0, rd_idx}, {28'd0, 4'(r + 5)});
      chk("R5 rn", {28'd0, src_n_idx}, r);
      chk("R5 rm", {28'd0, src_m_idx}, {28'd0, 4'(r + 9)});
      drive(1, 1, cp(r[3:0], 4'(r + 3), 4'(r + 7)), 32'd0, 32'd0, 4'd0, 0);
      chk("R6 rd", {28'd0, rd_idx}, {28'd0, 4'(r + 3)});
      chk("R6 rn", {28'd0, src_n_idx}, r);
      chk("R6 rm", {28'd0, src_m_idx}, {28'd0, 4'(r + 7)});
    end
    // R5/R6: any flipped constant bit breaks the match
    for (int b = 0; b < 32; b++) begin
      if ((b >= 20 && b <= 27) || (b >= 4 && b <= 11)) begin
        drive(1, 0, fx(4'hE, 4'd1, 4'd2, 4'd3) ^ (32'd1 << b), 32'd0, 32'd0, 4'd0, 0);
        chk("R5 bad opcode bit", {31'd0, illegal}, 32'd1);
      end
      if (b >= 20 || (b >= 12 && b <= 15) || (b >= 4 && b <= 7)) begin
        drive(1, 1, cp(4'd1, 4'd2, 4'd3) ^ (32'd1 << b), 32'd0, 32'd0, 4'd0, 0);
        chk("R6 bad opcode bit", {31'd0, illegal}, 32'd1);
        chk("R6 bad opcode no write", {31'd0, wr_en}, 32'd0);
      end
    end
    drive(1, 1, fx(4'hE, 4'd1, 4'd2, 4'd3), 32'd0, 32'd0, 4'd0, 0);
    chk("R6 wrong mode illegal", {31'd0, illegal}, 32'd1);
    drive(1, 0, cp(4'd1, 4'd2, 4'd3), 32'd0, 32'd0, 4'd0, 0);
    chk("R5 wrong mode illegal", {31'd0, illegal}, 32'd1);

    // R1/R2: corner pairs and pseudo-random operands
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        drive(1, 1, cp(4'd0, 4'd0, 4'd0), corner[i], corner[j], 4'd0, 0);
        chk(clamps(corner[i], corner[j]) ? "R2 clamp" : "R1 exact sum",
            result, sat_ref(corner[i], corner[j]));
      end
    lf = 32'hACE1_2345;
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a, b;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      b = lf ^ 32'h5A5A_0F0F;
      drive(1, 0, fx(4'hE, 4'd0, 4'd0, 4'd0), a, b, 4'd0, 0);
      chk(clamps(a, b) ? "R2 random clamp" : "R1 random sum", result, sat_ref(a, b));
    end

    // sticky-flag sequences
    do_reset();
    #1;
    chk("R10 flag after reset", {31'd0, sat_flag}, 32'd0);
    drive(1, 0, fx(4'hE, 4'd0, 4'd1, 4'd0), 32'h7FFF_FFFF, 32'd1, 4'd0, 0);
    chk("R2 positive limit", result, 32'h7FFF_FFFF);
    clock_in(32'd1, "R3 set on clamp");
    drive(1, 0, fx(4'hE, 4'd0, 4'd1, 4'd0), 32'd3, 32'd4, 4'd0, 0);
    clock_in(32'd1, "R3 sticky after plain add");
    drive(0, 0, 32'd0, 32'd0, 32'd0, 4'd0, 1);
    clock_in(32'd0, "R4 clear");
    // R4: clear and clamp in one cycle
    drive(1, 1, cp(4'd0, 4'd1, 4'd0), 32'h8000_0000, 32'hFFFF_FFFF, 4'd0, 1);
    chk("R2 negative limit", result, 32'h8000_0000);
    clock_in(32'd1, "R4 set beats clear");
    drive(1, 1, cp(4'd0, 4'd1, 4'd0), 32'd10, 32'd20, 4'd0, 1);
    clock_in(32'd0, "R4 clear with plain add");
    // R4/R7: clamp whose condition fails, with clear
    drive(1, 0, fx(4'h0, 4'd0, 4'd1, 4'd0), 32'h7FFF_FFFF, 32'h7FFF_FFFF, 4'd0, 1);
    chk("R7 failed cond no write", {31'd0, wr_en}, 32'd0);
    clock_in(32'd0, "R4 clear with failed clamp");
    // R7: failed condition does not set
    drive(1, 0, fx(4'h1, 4'd0, 4'd1, 4'd0), 32'h7FFF_FFFF, 32'h7FFF_FFFF, 4'b0100, 0);
    clock_in(32'd0, "R7 failed cond keeps flag");
    // R8: illegal word does not set
    drive(1, 0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0000, 4'd0, 0);
    chk("R8 illegal", {31'd0, illegal}, 32'd1);
    clock_in(32'd0, "R8 illegal keeps flag");
    // R11: idle cycle does not set
    drive(0, 0, fx(4'hE, 4'd0, 4'd1, 4'd0), 32'h7FFF_FFFF, 32'd9, 4'd0, 0);
    chk("R11 idle no write", {31'd0, wr_en}, 32'd0);
    chk("R11 idle no illegal", {31'd0, illegal}, 32'd0);
    clock_in(32'd0, "R11 idle keeps flag");
    // R10: reset clears a set flag
    drive(1, 1, cp(4'd0, 4'd1, 4'd0), 32'h7000_0000, 32'h7000_0000, 4'd0, 0);
    clock_in(32'd1, "R3 set before reset");
    do_reset();
    #1;
    chk("R10 reset clears set flag", {31'd0, sat_flag}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule